// File: doc/BRIEF.md
# Low-Power Mode Sequencer and Clock Enable Generator

This block decides, cycle by cycle, which parts of a small microcontroller receive a clock. It runs from the oscillator clock. It drives enables for the CPU, for the general peripherals, and for two fixed-rate consumers: the display driver and the 8-bit timer. A control field selects a power-of-two slowdown, which gives slow operation. Two instruction strobes put the core to sleep. The wait strobe stops only the CPU. The halt strobe also stops the oscillator and most consumers.

The block owns the interrupt-mask bit value. Entering wait clears the mask, so that any pending request can end the sleep. Interrupt entry and return strobes from the core save the mask, set it, and later restore it. The block chooses the legal wake events for each sleep state. Waking from halt, and any synchronous reset request, brings up the oscillator first. The core is then held for a fixed stabilisation window before it restarts. A two-bit code records why the last exit happened. It stays readable until the next sleep entry.

The enables are registered and change only at rising edges of the oscillator clock. A downstream latch-based clock gate samples them during the low phase, so no shortened pulse reaches any consumer.

Top module: `pwr_clk_seq`

## Requirements
- R1: After power-on reset the oscillator enable and the supply-supervisor enable are 1. The mask output is 1 and the wake code is 0. With `div_sel_i` = 0 the CPU enable is high on every cycle.
- R2: In run mode the CPU and peripheral enables pulse once every 2^min(`div_sel_i`,5) oscillator cycles. The period is 1, 2, 4, 8, 16 or 32 cycles, and codes 5, 6 and 7 all give 32.
- R3: In run and wait the display and timer enables pulse once every 2 oscillator cycles, whatever the value of `div_sel_i`.
- R4: A `wfi_i` pulse in run moves to wait on the next cycle. The CPU enable goes low, the oscillator and peripheral enables stay active, the mask output goes to 0 and the wake code goes to 0.
- R5: In wait, any `irq_i` line, `tmr_evt_i`, or `lvd_flag_i` while `lvd_en_i` is 1 returns the block to run on the next cycle with wake code 1. An `ext_wake_i` pin returns it with wake code 2. `lvd_flag_i` with `lvd_en_i` = 0 is ignored, and so are `halt_i` and `wfi_i` pulses.
- R6: `isr_enter_i` sets the mask to 1 and saves its previous value. `iret_i` restores the saved value.
- R7: A `halt_i` pulse in run moves to halt on the next cycle. The oscillator, CPU, peripheral, display, timer and supply-supervisor enables all go to 0. `lvd_on_o` then follows `lvd_en_i`.
- R8: Halt is left only by an `ext_wake_i` pin (wake code 2), by `tmr_evt_i` while `tmr_ext_clk_i` is 1 (wake code 1), or by `rst_req_i` (wake code 3). `irq_i`, and `tmr_evt_i` without the external clock, are ignored.
- R9: On a wake from halt the oscillator enable rises on the next cycle. The CPU and peripheral enables then stay low for exactly STAB_CYCLES (4096) cycles before run resumes.
- R10: `rst_req_i` in any state starts the STAB_CYCLES stabilisation hold, with wake code 3 and mask 1.
- R11: The wake code holds its value in run until the next wait or halt entry, which clears it to 0.
- R12: When several strobes arrive together in run, `rst_req_i` wins over `halt_i`, and `halt_i` wins over `wfi_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| div_sel_i | input | 3 | Slow-mode divider code: divide by 2^min(code,5) |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| halt_i | input | 1 | Halt strobe |
| rst_req_i | input | 1 | Synchronous reset request (pin or watchdog) |
| irq_i | input | 4 | Interrupt request lines |
| ext_wake_i | input | 2 | External I/O wake pins |
| tmr_evt_i | input | 1 | Timer wake event |
| tmr_ext_clk_i | input | 1 | Timer is clocked externally |
| lvd_en_i | input | 1 | Low-voltage detector enable bit |
| lvd_flag_i | input | 1 | Low-voltage detector flag |
| isr_enter_i | input | 1 | Core has entered an interrupt routine |
| iret_i | input | 1 | Core has popped its saved condition state |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 1 | General peripheral clock enable |
| lcd_ce_o | output | 1 | Display driver fixed-rate enable |
| tmr_ce_o | output | 1 | Timer fixed-rate enable |
| sss_en_o | output | 1 | Supply supervisor enable |
| lvd_on_o | output | 1 | Low-voltage detector power |
| mask_o | output | 1 | Interrupt mask bit value |
| wake_o | output | 2 | Wake cause: 0 none, 1 interrupt, 2 external pin, 3 reset |

## Verification
The stabilisation window is the hardest case to reach from the ports. It lasts thousands of cycles, and it is entered only from halt or by a reset request. A wrong count shows up only as a CPU enable that rises one cycle early or late. The stimulus first parks the block in halt and offers each wake source, legal and illegal. For every legal exit it then counts, one cycle at a time, the cycles in which the oscillator runs while the CPU enable stays low, and compares that count with the window length. The wait-mode reset request is driven the same way.

// File: rtl/pwr_clk_seq.sv
module pwr_clk_seq #(
  parameter int NIRQ        = 4,
  parameter int NEXT        = 2,
  parameter int SEL_W       = 3,
  parameter int PRE_W       = 5,
  parameter int FIX_LOG2    = 1,
  parameter int STAB_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             wfi_i,
  input  logic             halt_i,
  input  logic             rst_req_i,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic [NEXT-1:0]  ext_wake_i,
  input  logic             tmr_evt_i,
  input  logic             tmr_ext_clk_i,
  input  logic             lvd_en_i,
  input  logic             lvd_flag_i,
  input  logic             isr_enter_i,
  input  logic             iret_i,
  output logic             osc_en_o,
  output logic             cpu_ce_o,
  output logic             per_ce_o,
  output logic             lcd_ce_o,
  output logic             tmr_ce_o,
  output logic             sss_en_o,
  output logic             lvd_on_o,
  output logic             mask_o,
  output logic [1:0]       wake_o
);

  localparam int CNT_W = $clog2(STAB_CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STAB_CYCLES - 1);
  localparam logic [1:0] C_NONE = 2'd0, C_IRQ = 2'd1, C_EXT = 2'd2, C_RST = 2'd3;

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_HALT, S_STAB} st_t;

  st_t              st, st_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic [1:0]       cause_d;
  logic [PRE_W-1:0] pre, pre_d, low_mask;
  logic [SEL_W-1:0] k;
  logic             saved;
  logic             wait_wake, ext_any, halt_tmr, div_tick, fix_tick, awake_d;

  assign ext_any   = |ext_wake_i;
  assign wait_wake = |irq_i | tmr_evt_i | (lvd_flag_i & lvd_en_i);
  assign halt_tmr  = tmr_evt_i & tmr_ext_clk_i;

  always_comb begin
    st_d    = st;
    cnt_d   = cnt;
    cause_d = wake_o;
    if (rst_req_i) begin
      st_d    = S_STAB;
      cnt_d   = LOAD;
      cause_d = C_RST;
    end else begin
      case (st)
        S_RUN:
          if (halt_i) begin
            st_d    = S_HALT;
            cause_d = C_NONE;
          end else if (wfi_i) begin
            st_d    = S_WAIT;
            cause_d = C_NONE;
          end
        S_WAIT:
          if (ext_any) begin
            st_d    = S_RUN;
            cause_d = C_EXT;
          end else if (wait_wake) begin
            st_d    = S_RUN;
            cause_d = C_IRQ;
          end
        S_HALT:
          if (ext_any) begin
            st_d    = S_STAB;
            cnt_d   = LOAD;
            cause_d = C_EXT;
          end else if (halt_tmr) begin
            st_d    = S_STAB;
            cnt_d   = LOAD;
            cause_d = C_IRQ;
          end
        default:
          if (cnt == '0) st_d = S_RUN;
          else           cnt_d = cnt - CNT_W'(1);
      endcase
    end
  end

  assign pre_d    = (st_d == S_HALT) ? pre : pre + PRE_W'(1);
  assign k        = (div_sel_i > SEL_W'(PRE_W)) ? SEL_W'(PRE_W) : div_sel_i;
  assign low_mask = ~({PRE_W{1'b1}} << k);
  assign div_tick = (pre_d & low_mask) == low_mask;
  assign fix_tick = &pre_d[FIX_LOG2-1:0];
  assign awake_d  = (st_d == S_RUN) || (st_d == S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      cnt      <= '0;
      pre      <= '0;
      wake_o   <= C_NONE;
      osc_en_o <= 1'b1;
      cpu_ce_o <= 1'b0;
      per_ce_o <= 1'b0;
      lcd_ce_o <= 1'b0;
      tmr_ce_o <= 1'b0;
      sss_en_o <= 1'b1;
      lvd_on_o <= 1'b1;
    end else begin
      st       <= st_d;
      cnt      <= cnt_d;
      pre      <= pre_d;
      wake_o   <= cause_d;
      osc_en_o <= st_d != S_HALT;
      cpu_ce_o <= (st_d == S_RUN) & div_tick;
      per_ce_o <= awake_d & div_tick;
      lcd_ce_o <= awake_d & fix_tick;
      tmr_ce_o <= awake_d & fix_tick;
      sss_en_o <= st_d != S_HALT;
      lvd_on_o <= lvd_en_i | (st_d != S_HALT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= 1'b1;
      saved  <= 1'b1;
    end else if (rst_req_i) begin
      mask_o <= 1'b1;
      saved  <= 1'b1;
    end else if (st == S_RUN && st_d == S_WAIT) begin
      mask_o <= 1'b0;
    end else if (isr_enter_i) begin
      saved  <= mask_o;
      mask_o <= 1'b1;
    end else if (iret_i) begin
      mask_o <= saved;
    end
  end

  p_wfi_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && wfi_i && !halt_i && !rst_req_i) |=>
      (!cpu_ce_o && osc_en_o && !mask_o && wake_o == 2'd0));

  p_halt_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && halt_i && !rst_req_i) |=>
      (!osc_en_o && !cpu_ce_o && !per_ce_o && !lcd_ce_o && !tmr_ce_o && !sss_en_o));

  p_halt_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT && !rst_req_i && !ext_any && !halt_tmr) |=> !osc_en_o);

  p_stab_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STAB) |-> (osc_en_o && !cpu_ce_o && !per_ce_o));

  p_reset_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> (wake_o == 2'd3 && mask_o && !cpu_ce_o));

  p_cause_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !rst_req_i && !wfi_i && !halt_i) |=> $stable(wake_o));

endmodule

// File: tb/tb_pwr_clk_seq.sv
module tb_pwr_clk_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] div_sel = '0;
  logic wfi = 0, halt = 0, rst_req = 0, tmr_evt = 0, tmr_ext = 0;
  logic lvd_en = 0, lvd_flag = 0, isr_enter = 0, iret = 0;
  logic [3:0] irq = '0;
  logic [1:0] ext = '0;
  logic osc_en, cpu_ce, per_ce, lcd_ce, tmr_ce, sss_en, lvd_on, mask;
  logic [1:0] wake;
  int checks = 0, errors = 0;

  localparam int STAB = 4096;
  localparam int NV = 6;
  localparam int TBL_DIV [NV] = '{0, 1, 2, 3, 5, 7};
  localparam int TBL_PER [NV] = '{1, 2, 4, 8, 32, 32};

  always #10 clk = ~clk;

  pwr_clk_seq dut (
    .clk(clk), .rst_n(rst_n), .div_sel_i(div_sel), .wfi_i(wfi), .halt_i(halt),
    .rst_req_i(rst_req), .irq_i(irq), .ext_wake_i(ext), .tmr_evt_i(tmr_evt),
    .tmr_ext_clk_i(tmr_ext), .lvd_en_i(lvd_en), .lvd_flag_i(lvd_flag),
    .isr_enter_i(isr_enter), .iret_i(iret), .osc_en_o(osc_en), .cpu_ce_o(cpu_ce),
    .per_ce_o(per_ce), .lcd_ce_o(lcd_ce), .tmr_ce_o(tmr_ce), .sss_en_o(sss_en),
    .lvd_on_o(lvd_on), .mask_o(mask), .wake_o(wake));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    wfi = 0; halt = 0; rst_req = 0; irq = '0; ext = '0; tmr_evt = 0;
    lvd_flag = 0; isr_enter = 0; iret = 0;
  endtask

  task automatic period(input logic sel_fix, output int n);
    n = 0;
    while (!(sel_fix ? lcd_ce : cpu_ce)) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!(sel_fix ? lcd_ce : cpu_ce) && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic hold_len(output int n);
    n = 0;
    while (!cpu_ce && n < 10000) begin
      if (osc_en && !per_ce) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cyc(2); rst_n = 1; cyc(3);
    // R1 reset state
    chk("R1 osc_en", osc_en, 1); chk("R1 sss_en", sss_en, 1);
    chk("R1 mask", mask, 1); chk("R1 wake", wake, 0); chk("R1 cpu_ce", cpu_ce, 1);

    // R2 / R3 divider table
    for (int v = 0; v < NV; v++) begin
      div_sel = 3'(TBL_DIV[v]);
      cyc(40);
      period(1'b0, n); chk($sformatf("R2 div %0d", TBL_DIV[v]), n, TBL_PER[v]);
      period(1'b1, n); chk($sformatf("R3 div %0d", TBL_DIV[v]), n, 2);
    end
    div_sel = 3'd0; cyc(4);

    // R4 wait entry, R3 fixed clock in wait
    wfi = 1; cyc(1); clear_all();
    chk("R4 cpu_ce", cpu_ce, 0); chk("R4 osc_en", osc_en, 1);
    chk("R4 per_ce", per_ce, 1); chk("R4 mask", mask, 0); chk("R4 wake", wake, 0);
    period(1'b1, n); chk("R3 wait lcd", n, 2);
    // R5 ignored inputs in wait
    halt = 1; cyc(1); clear_all(); chk("R5 halt ignored osc", osc_en, 1);
    lvd_flag = 1; cyc(1); clear_all(); chk("R5 lvd disabled ignored", cpu_ce, 0);
    // R5 irq wake
    irq = 4'b0100; cyc(1); clear_all();
    chk("R5 irq wake cpu", cpu_ce, 1); chk("R5 irq wake code", wake, 1);
    // R6 mask save and restore
    isr_enter = 1; cyc(1); clear_all(); chk("R6 isr mask", mask, 1);
    iret = 1; cyc(1); clear_all(); chk("R6 iret restore", mask, 0);
    // R11 cause held in run
    cyc(20); chk("R11 cause held", wake, 1);
    // R5 lvd wake with enable
    wfi = 1; cyc(1); clear_all(); chk("R11 cleared on entry", wake, 0);
    lvd_en = 1; lvd_flag = 1; cyc(1); clear_all();
    chk("R5 lvd wake", wake, 1); chk("R5 lvd cpu", cpu_ce, 1);
    // R5 ext pin wake from wait
    wfi = 1; cyc(1); clear_all();
    ext = 2'b10; cyc(1); clear_all(); chk("R5 ext wake code", wake, 2);

    // R7 halt entry
    lvd_en = 0; halt = 1; cyc(1); clear_all();
    chk("R7 osc", osc_en, 0); chk("R7 cpu", cpu_ce, 0); chk("R7 per", per_ce, 0);
    chk("R7 lcd", lcd_ce, 0); chk("R7 tmr", tmr_ce, 0); chk("R7 sss", sss_en, 0);
    chk("R7 lvd off", lvd_on, 0);
    lvd_en = 1; cyc(1); chk("R7 lvd kept", lvd_on, 1); lvd_en = 0;
    // R8 ignored sources
    irq = 4'hF; cyc(1); clear_all(); chk("R8 irq ignored", osc_en, 0);
    tmr_evt = 1; cyc(1); clear_all(); chk("R8 timer w/o ext clk", osc_en, 0);
    lvd_en = 1; lvd_flag = 1; cyc(1); clear_all(); lvd_en = 0;
    chk("R8 lvd ignored", osc_en, 0); chk("R8 wake code idle", wake, 0);
    // R9 ext wake, stabilisation
    ext = 2'b01; cyc(1); clear_all();
    chk("R9 osc first", osc_en, 1); chk("R9 cpu gated", cpu_ce, 0);
    hold_len(n); chk("R9 hold length", n, STAB); chk("R8 ext code", wake, 2);
    // R8 timer wake with external clock
    halt = 1; cyc(1); clear_all();
    tmr_ext = 1; tmr_evt = 1; cyc(1); clear_all(); tmr_ext = 0;
    hold_len(n); chk("R9 timer hold", n, STAB); chk("R8 timer code", wake, 1);

    // R10 reset request from wait
    wfi = 1; cyc(1); clear_all();
    rst_req = 1; cyc(1); clear_all();
    chk("R10 mask", mask, 1); chk("R10 code", wake, 3);
    hold_len(n); chk("R10 hold length", n, STAB);

    // R12 priority: halt over wfi, then reset over halt
    halt = 1; wfi = 1; cyc(1); clear_all();
    chk("R12 halt beats wfi", osc_en, 0);
    ext = 2'b01; cyc(1); clear_all(); hold_len(n);
    rst_req = 1; halt = 1; cyc(1); clear_all();
    chk("R12 reset beats halt osc", osc_en, 1); chk("R12 reset code", wake, 3);
    hold_len(n); chk("R12 reset hold", n, STAB);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule